// File: doc/BRIEF.md
# PWM Fault Brake Controller

This block sits between a PWM generator and its six output pins. It gathers fault sources into two brake functions and, while any brake is active, replaces every channel's PWM level with a per-channel safe level. The fault sources are an external brake pin for each brake function, two analog comparator fault lines, an ADC fault line, a software brake control and a low-voltage detect line. The pin path can optionally pass through a noise filter. Comparators and the ADC are outside the block; only their fault outputs enter it.

Each brake function has its own enable for each of its four event sources. When an enabled event occurs, it sets a sticky brake flag. The flag holds the brake until software clears it with a write-1 pulse. Each flag raises the interrupt line only when its interrupt enable is set.

The low-voltage line works differently. It brakes only through brake function 1 and sets no flag. After the line drops, the brake is released in one of two ways: either when a programmed 12-bit delay has counted out, or at the next PWM period edge. The software brake is a level: the outputs are overridden for exactly as long as it is held.

Top module: `pwm_fault_brake`

## Requirements
- R1: After synchronous reset both flags read 0, `irq` is 0 and `pwm_out` equals `pwm_in`.
- R2: With the filter off, a falling edge on `brk_pin_n[b]` sets `brk_flag[b]` when bit 3 of that brake's source enable is set. The flag reads 1 after the second rising clock edge that samples the pin low.
- R3: With `filt_en` set, the pin must be sampled low on 3 consecutive edges before the edge is accepted, so the flag reads 1 after the fifth such edge. A low pulse of 2 samples sets nothing.
- R4: Source-enable bit positions for each brake are: bit 0 comparator 0 fault, bit 1 comparator 1 fault, bit 2 ADC fault, bit 3 pin. A high comparator or ADC line sets the flag on the next edge only if its bit is set. A disabled source changes nothing.
- R5: A 1 on `clr_flag[b]` clears `brk_flag[b]` at the next edge. If a set event occurs in the same cycle, the flag stays 1.
- R6: A flag stays set after its source returns to idle.
- R7: While `sw_brake` is 1, `pwm_out` shows the safe levels with no clock delay. Clearing it restores `pwm_in` at once, provided no other brake is active.
- R8: While any brake is active, each `pwm_out[c]` equals `brake_lvl[c]` (0 drives low, 1 drives high). Otherwise it equals `pwm_in[c]`.
- R9: `irq` is 1 exactly when some `brk_flag[b]` and `irq_en[b]` are both 1.
- R10: With `lvd_en` set, a high `lvd_fault` brakes the outputs from the next edge and sets no flag. With `lvd_en` clear, the line has no effect.
- R11: With `lvd_resume_edge` 0, the brake is held for `lvd_delay`+1 edges after the first edge that samples `lvd_fault` low, and is released at the following edge.
- R12: With `lvd_resume_edge` 1, the brake is released at the first edge that samples `period_edge` high after the edge that first sampled `lvd_fault` low. A period edge sampled at that same edge does not release the brake.
- R13: If `lvd_fault` returns high during the release countdown, the countdown restarts in full once the line drops again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_pin_n | input | 2 | Brake pins, active falling edge, one per brake function |
| filt_en | input | 1 | Enable the pin noise filter |
| cmp0_fault | input | 1 | Comparator 0 fault line |
| cmp1_fault | input | 1 | Comparator 1 fault line |
| adc_fault | input | 1 | ADC fault line |
| src_en0 | input | 4 | Source enables for brake 0 |
| src_en1 | input | 4 | Source enables for brake 1 |
| sw_brake | input | 1 | Software brake level |
| lvd_fault | input | 1 | Low-voltage detect line |
| lvd_en | input | 1 | Let low-voltage detect drive brake 1 |
| lvd_resume_edge | input | 1 | 0: delay release, 1: period-edge release |
| lvd_delay | input | 12 | Release delay count |
| period_edge | input | 1 | One-cycle pulse at each PWM period edge |
| clr_flag | input | 2 | Write-1-to-clear pulses for the flags |
| irq_en | input | 2 | Interrupt enables per flag |
| brake_lvl | input | 6 | Safe level per channel |
| pwm_in | input | 6 | Raw PWM levels |
| pwm_out | output | 6 | Overridden channel levels |
| brk_flag | output | 2 | Latched brake flags |
| irq | output | 1 | Brake interrupt request |

## Verification
The bench builds the block with its defaults: six channels, a 3-sample filter and a 12-bit delay. The 3-sample window makes a 2-sample glitch short enough to be rejected and a 3-sample low long enough to be accepted, within a few cycles. A small programmed delay of 5 lets the exact release edge of the countdown be pinned down, along with a restart partway through. The six-channel width lets alternating safe and PWM patterns expose any crossed or stuck channel.

// File: rtl/pwm_brk_pkg.sv
package pwm_brk_pkg;

    localparam int NUM_BRK  = 2;
    localparam int NUM_SRC  = 4;

    // Fault event vector; packed so bit 0 is comparator 0, bit 3 is the pin.
    typedef struct packed {
        logic pin_fall;
        logic adc;
        logic cmp1;
        logic cmp0;
    } fault_vec_t;

    typedef enum logic [1:0] {
        LV_IDLE  = 2'd0,
        LV_FAULT = 2'd1,
        LV_WAIT  = 2'd2
    } lv_state_e;

    function automatic logic src_hit(input logic [NUM_SRC-1:0] en, input fault_vec_t ev);
        return |(en & ev);
    endfunction

endpackage

// File: rtl/brk_pin_filter.sv
module brk_pin_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic filt_en_i,
    output logic fall_o
);
    logic [FILT_LEN-1:0] sh;
    logic                filt_lvl;
    logic                prev_sel;
    logic                sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '1;
            filt_lvl <= 1'b1;
            prev_sel <= 1'b1;
        end else begin
            sh <= {sh[FILT_LEN-2:0], pin_i};
            if (&sh)
                filt_lvl <= 1'b1;
            else if (~|sh)
                filt_lvl <= 1'b0;
            prev_sel <= sel;
        end
    end

    assign sel    = filt_en_i ? filt_lvl : sh[0];
    assign fall_o = prev_sel & ~sel;

    // The filtered level only drops after a full window of low samples.
    assert_filt_stable_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(filt_lvl) |-> ($past(sh) == '0));

endmodule

// File: rtl/brk_flag_latch.sv
module brk_flag_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/lvd_resume_ctrl.sv
module lvd_resume_ctrl
    import pwm_brk_pkg::*;
#(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvd_i,
    input  logic             lvd_en_i,
    input  logic             edge_mode_i,
    input  logic             period_edge_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             active_o
);
    lv_state_e        state;
    logic [DLY_W-1:0] cnt;
    logic             fault;

    assign fault = lvd_i & lvd_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LV_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                LV_IDLE: begin
                    if (fault) begin
                        state <= LV_FAULT;
                        cnt   <= dly_i;
                    end
                end
                LV_FAULT: begin
                    cnt <= dly_i;
                    if (!lvd_i)
                        state <= LV_WAIT;
                end
                LV_WAIT: begin
                    if (fault) begin
                        state <= LV_FAULT;
                        cnt   <= dly_i;
                    end else if (edge_mode_i) begin
                        if (period_edge_i)
                            state <= LV_IDLE;
                    end else if (cnt == '0) begin
                        state <= LV_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= LV_IDLE;
            endcase
        end
    end

    assign active_o = (state != LV_IDLE);

    assert_countdown_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (state == LV_WAIT && !edge_mode_i && cnt != '0) |=> active_o);

    assert_edge_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (active_o && edge_mode_i && !period_edge_i) |=> active_o);

endmodule

// File: rtl/pwm_fault_brake.sv
module pwm_fault_brake
    import pwm_brk_pkg::*;
#(
    parameter int NUM_CH   = 6,
    parameter int FILT_LEN = 3,
    parameter int DLY_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        brk_pin_n,
    input  logic              filt_en,
    input  logic              cmp0_fault,
    input  logic              cmp1_fault,
    input  logic              adc_fault,
    input  logic [3:0]        src_en0,
    input  logic [3:0]        src_en1,
    input  logic              sw_brake,
    input  logic              lvd_fault,
    input  logic              lvd_en,
    input  logic              lvd_resume_edge,
    input  logic [DLY_W-1:0]  lvd_delay,
    input  logic              period_edge,
    input  logic [1:0]        clr_flag,
    input  logic [1:0]        irq_en,
    input  logic [NUM_CH-1:0] brake_lvl,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [1:0]        brk_flag,
    output logic              irq
);
    logic [NUM_BRK-1:0][NUM_SRC-1:0] src_en;
    logic [NUM_BRK-1:0]              pin_fall;
    logic [NUM_BRK-1:0]              set_ev;
    logic                            lvd_active;
    logic                            brake_on;

    assign src_en[0] = src_en0;
    assign src_en[1] = src_en1;

    for (genvar b = 0; b < NUM_BRK; b++) begin : g_brk
        fault_vec_t ev;

        brk_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk       (clk),
            .rst       (rst),
            .pin_i     (brk_pin_n[b]),
            .filt_en_i (filt_en),
            .fall_o    (pin_fall[b])
        );

        assign ev.cmp0     = cmp0_fault;
        assign ev.cmp1     = cmp1_fault;
        assign ev.adc      = adc_fault;
        assign ev.pin_fall = pin_fall[b];
        assign set_ev[b]   = src_hit(src_en[b], ev);

        brk_flag_latch u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_ev[b]),
            .clr_i  (clr_flag[b]),
            .flag_o (brk_flag[b])
        );
    end

    lvd_resume_ctrl #(.DLY_W(DLY_W)) u_lvd (
        .clk           (clk),
        .rst           (rst),
        .lvd_i         (lvd_fault),
        .lvd_en_i      (lvd_en),
        .edge_mode_i   (lvd_resume_edge),
        .period_edge_i (period_edge),
        .dly_i         (lvd_delay),
        .active_o      (lvd_active)
    );

    assign brake_on = (|brk_flag) | sw_brake | lvd_active;
    assign pwm_out  = brake_on ? brake_lvl : pwm_in;
    assign irq      = |(brk_flag & irq_en);

    assert_flag_override_R8: assert property (@(posedge clk) disable iff (rst)
        (|brk_flag) |-> (pwm_out == brake_lvl));

endmodule

// File: tb/pwm_fault_brake_tb.sv
module pwm_fault_brake_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] brk_pin_n = 2'b11;
    logic filt_en = 1'b0, cmp0_fault = 1'b0, cmp1_fault = 1'b0, adc_fault = 1'b0;
    logic [3:0] src_en0 = '0, src_en1 = '0;
    logic sw_brake = 1'b0, lvd_fault = 1'b0, lvd_en = 1'b0, lvd_resume_edge = 1'b0;
    logic [11:0] lvd_delay = '0;
    logic period_edge = 1'b0;
    logic [1:0] clr_flag = '0, irq_en = '0;
    logic [NCH-1:0] brake_lvl = 6'h2A, pwm_in = 6'h15;
    logic [NCH-1:0] pwm_out;
    logic [1:0] brk_flag;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_fault_brake u_dut (
        .clk(clk), .rst(rst), .brk_pin_n(brk_pin_n), .filt_en(filt_en),
        .cmp0_fault(cmp0_fault), .cmp1_fault(cmp1_fault), .adc_fault(adc_fault),
        .src_en0(src_en0), .src_en1(src_en1), .sw_brake(sw_brake),
        .lvd_fault(lvd_fault), .lvd_en(lvd_en), .lvd_resume_edge(lvd_resume_edge),
        .lvd_delay(lvd_delay), .period_edge(period_edge), .clr_flag(clr_flag),
        .irq_en(irq_en), .brake_lvl(brake_lvl), .pwm_in(pwm_in),
        .pwm_out(pwm_out), .brk_flag(brk_flag), .irq(irq)
    );

    // {sw_brake, pwm_in, brake_lvl, expected pwm_out}
    localparam logic [18:0] VEC [6] = '{
        {1'b0, 6'h15, 6'h2A, 6'h15},
        {1'b1, 6'h15, 6'h2A, 6'h2A},
        {1'b1, 6'h3F, 6'h00, 6'h00},
        {1'b1, 6'h00, 6'h3F, 6'h3F},
        {1'b0, 6'h0F, 6'h30, 6'h0F},
        {1'b1, 6'h0F, 6'h30, 6'h30}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        clr_flag = m;
        tick(1);
        clr_flag = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(brk_flag == 2'b00, "R1 flags", brk_flag, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(pwm_out == pwm_in, "R1 pass", pwm_out, pwm_in);

        // R7 R8 table walk
        for (int i = 0; i < 6; i++) begin
            sw_brake  = VEC[i][18];
            pwm_in    = VEC[i][17:12];
            brake_lvl = VEC[i][11:6];
            #1;
            chk(pwm_out == VEC[i][5:0], "R7 R8 vector", pwm_out, VEC[i][5:0]);
            tick(1);
        end
        sw_brake = 1'b0; pwm_in = 6'h15; brake_lvl = 6'h2A;
        #1;
        chk(pwm_out == 6'h15, "R7 release", pwm_out, 6'h15);
        tick(1);

        // R2 unfiltered pin on brake 0
        src_en0 = 4'b1000;
        brk_pin_n[0] = 1'b0;
        tick(1);
        chk(brk_flag[0] == 1'b0, "R2 not yet", brk_flag[0], 0);
        tick(1);
        chk(brk_flag[0] == 1'b1, "R2 set", brk_flag[0], 1);
        chk(pwm_out == 6'h2A, "R8 flag override", pwm_out, 6'h2A);
        brk_pin_n[0] = 1'b1;
        tick(3);
        chk(brk_flag[0] == 1'b1, "R6 latched", brk_flag[0], 1);
        // R9 irq gating
        irq_en = 2'b10; #1;
        chk(irq == 1'b0, "R9 masked", irq, 0);
        irq_en = 2'b01; #1;
        chk(irq == 1'b1, "R9 raised", irq, 1);
        irq_en = 2'b00;
        pulse_clr(2'b01);
        chk(brk_flag[0] == 1'b0, "R5 clear", brk_flag[0], 0);
        chk(pwm_out == 6'h15, "R8 restored", pwm_out, 6'h15);

        // R3 filtered pin on brake 1
        src_en1 = 4'b1000; filt_en = 1'b1;
        tick(4);
        brk_pin_n[1] = 1'b0;
        tick(2);
        brk_pin_n[1] = 1'b1;
        tick(6);
        chk(brk_flag[1] == 1'b0, "R3 glitch rejected", brk_flag[1], 0);
        brk_pin_n[1] = 1'b0;
        tick(4);
        chk(brk_flag[1] == 1'b0, "R3 fourth edge", brk_flag[1], 0);
        tick(1);
        chk(brk_flag[1] == 1'b1, "R3 fifth edge", brk_flag[1], 1);
        brk_pin_n[1] = 1'b1;
        tick(5);
        pulse_clr(2'b10);
        filt_en = 1'b0; src_en1 = '0; src_en0 = '0;
        tick(2);

        // R4 source enables
        src_en0 = 4'b0011;
        adc_fault = 1'b1;
        tick(2);
        chk(brk_flag == 2'b00, "R4 adc disabled", brk_flag, 0);
        adc_fault = 1'b0;
        cmp1_fault = 1'b1;
        tick(1);
        chk(brk_flag == 2'b01, "R4 cmp1 to brake0", brk_flag, 1);
        cmp1_fault = 1'b0;
        pulse_clr(2'b01);
        src_en0 = '0; src_en1 = 4'b0100;
        adc_fault = 1'b1;
        tick(1);
        chk(brk_flag == 2'b10, "R4 adc to brake1", brk_flag, 2);
        // R5 set wins over clear
        pulse_clr(2'b10);
        chk(brk_flag[1] == 1'b1, "R5 set wins", brk_flag[1], 1);
        adc_fault = 1'b0;
        pulse_clr(2'b10);
        chk(brk_flag[1] == 1'b0, "R5 cleared", brk_flag[1], 0);
        src_en1 = '0;

        // R10 lvd disabled, then enabled
        lvd_fault = 1'b1;
        tick(3);
        chk(pwm_out == 6'h15, "R10 lvd disabled", pwm_out, 6'h15);
        lvd_fault = 1'b0;
        tick(1);
        lvd_en = 1'b1; lvd_delay = 12'd5; lvd_resume_edge = 1'b0;
        lvd_fault = 1'b1;
        tick(1);
        chk(pwm_out == 6'h2A, "R10 lvd brake", pwm_out, 6'h2A);
        chk(brk_flag == 2'b00, "R10 no flag", brk_flag, 0);
        // R11 countdown
        lvd_fault = 1'b0;
        tick(6);
        chk(pwm_out == 6'h2A, "R11 held", pwm_out, 6'h2A);
        tick(1);
        chk(pwm_out == 6'h15, "R11 released", pwm_out, 6'h15);

        // R13 restart
        lvd_fault = 1'b1; tick(1);
        lvd_fault = 1'b0; tick(3);
        lvd_fault = 1'b1; tick(1);
        lvd_fault = 1'b0;
        tick(6);
        chk(pwm_out == 6'h2A, "R13 restarted", pwm_out, 6'h2A);
        tick(1);
        chk(pwm_out == 6'h15, "R13 released", pwm_out, 6'h15);

        // R12 period-edge resume
        lvd_resume_edge = 1'b1;
        lvd_fault = 1'b1; tick(1);
        lvd_fault = 1'b0; period_edge = 1'b1;
        tick(1);
        period_edge = 1'b0;
        chk(pwm_out == 6'h2A, "R12 same-edge ignored", pwm_out, 6'h2A);
        tick(10);
        chk(pwm_out == 6'h2A, "R12 waiting", pwm_out, 6'h2A);
        period_edge = 1'b1;
        tick(1);
        period_edge = 1'b0;
        chk(pwm_out == 6'h15, "R12 released", pwm_out, 6'h15);

        // R1 reset again clears a flag
        src_en0 = 4'b0001; cmp0_fault = 1'b1; tick(1);
        cmp0_fault = 1'b0;
        rst = 1'b1; tick(1); rst = 1'b0; tick(1);
        chk(brk_flag == 2'b00, "R1 reset clears", brk_flag, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule